// File: doc/BRIEF.md
# Address Table Scan Engine

This block walks a learned-address table one slot at a time, under the control of a host. The host starts a scan by writing a command word to the control register. The engine then reads table slots in ascending order and skips every slot that holds no entry. It stops at the first occupied slot. At that point it drops its busy flag and raises a hit flag. It also copies the entry's attribute word and its 48-bit MAC address into result registers that the host can read.

A second command word resumes the scan from the slot after the last hit. An end flag tells the host that the slot just examined was the final one. The end flag is set both when the scan stops on the last slot with a hit and when the scan runs off the end without finding an entry.

The table sits outside the block and is reached through a synchronous read port. The engine drives an enable and a slot index, and the data comes back one cycle later. Learning, aging and forwarding lookups belong to other logic. The reset input is asynchronous and active low, and it must be deasserted synchronously to the clock.

Top module: `ats_top`

## Requirements
- R1: After reset, all four registers read as zero and the table read enable is low.
- R2: A write of exactly 0x0000_8004 to register 0 (control) starts a scan at slot 0 when the engine is not busy. From the next cycle, control bit 15 (busy) reads 1 and bits 14 (end) and 13 (hit) read 0. All other control bits always read 0.
- R3: A slot is occupied when bits 31:24 of its attribute word are not all zero. Empty slots are skipped. Each examined slot keeps busy high for exactly two cycles, so a scan that stops at the n-th slot it examines is busy for 2n cycles.
- R4: When an occupied slot is found, busy clears and hit sets in the same cycle. Register 1 returns that slot's attribute word, whose port bitmap sits in bits 11:4. Register 2 returns MAC bits 47:16. Register 3 returns MAC bits 15:0 in its low half, with the upper half zero.
- R5: A write of exactly 0x0000_8005 to register 0, while idle with hit set and end clear, clears hit and resumes the scan at the slot after the one that hit.
- R6: If the scan stops on the last slot with a hit, hit and end are both set. If it passes the last slot without finding an entry, end is set, hit is clear, and registers 1 to 3 keep their earlier values.
- R7: These writes have no effect: any command while busy, the resume command unless hit=1 and end=0, any other value written to register 0, and any write to registers 1 to 3.
- R8: The table read enable is high only while busy. Successive reads within a scan present consecutive slot indices, starting from the scan's first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write index (0 control, 1 attribute, 2 MAC high, 3 MAC low) |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 2 | Register read index |
| reg_rd_data | output | 32 | Register read data, combinational from reg_rd_addr |
| tbl_rd_en | output | 1 | Table read enable |
| tbl_rd_addr | output | $clog2(DEPTH) | Table slot index |
| tbl_rd_attr | input | 32 | Attribute word of the slot read in the previous cycle |
| tbl_rd_mac | input | 48 | MAC address of the slot read in the previous cycle |

## Verification
The assertions rely on two properties of the table. First, it returns the requested slot's attribute and MAC exactly one cycle after the read enable. Second, its contents stay fixed while a scan is in flight. The bench models the table as a synchronous array and rewrites it only when the engine is idle. The bench also drives every register write one full cycle wide, clear of the clock edge. Under these conditions, each occupied slot found maps to a single, predictable cycle at which the scan completes.

// File: rtl/ats_pkg.sv
package ats_pkg;
  localparam logic [31:0] ATS_CMD_START = 32'h0000_8004;
  localparam logic [31:0] ATS_CMD_NEXT  = 32'h0000_8005;

  localparam int ATS_BUSY_BIT = 15;
  localparam int ATS_END_BIT  = 14;
  localparam int ATS_HIT_BIT  = 13;

  localparam int ATS_VALID_MSB = 31;
  localparam int ATS_VALID_LSB = 24;

  typedef enum logic [1:0] {
    ATS_IDLE  = 2'd0,
    ATS_FETCH = 2'd1,
    ATS_CHECK = 2'd2
  } ats_state_e;

  typedef enum logic [1:0] {
    ATS_RA_CTRL   = 2'd0,
    ATS_RA_ATTR   = 2'd1,
    ATS_RA_MAC_HI = 2'd2,
    ATS_RA_MAC_LO = 2'd3
  } ats_reg_e;
endpackage

// File: rtl/ats_cmd_decode.sv
module ats_cmd_decode
  import ats_pkg::*;
(
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        busy,
  input  logic        hit,
  input  logic        fin,
  output logic        start_go,
  output logic        next_go
);
  logic ctrl_wr;

  always_comb begin
    ctrl_wr  = wr_en && (ats_reg_e'(wr_addr) == ATS_RA_CTRL) && !busy;
    start_go = ctrl_wr && (wr_data == ATS_CMD_START);
    next_go  = ctrl_wr && (wr_data == ATS_CMD_NEXT) && hit && !fin;
  end
endmodule

// File: rtl/ats_walker.sv
module ats_walker
  import ats_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_go,
  input  logic          next_go,
  input  logic          slot_valid,
  output logic          busy,
  output logic          hit,
  output logic          fin,
  output logic          capture,
  output logic          tbl_rd_en,
  output logic [AW-1:0] tbl_rd_addr
);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  ats_state_e    state_q, state_d;
  logic [AW-1:0] pos_q, pos_d;
  logic          hit_q, hit_d;
  logic          fin_q, fin_d;
  logic          step_en;
  logic          at_last;

  always_comb begin
    at_last = (pos_q == LAST_SLOT);
    step_en = (state_q != ATS_IDLE) || start_go || next_go;
    state_d = state_q;
    pos_d   = pos_q;
    hit_d   = hit_q;
    fin_d   = fin_q;
    capture = 1'b0;
    case (state_q)
      ATS_IDLE: begin
        if (start_go) begin
          state_d = ATS_FETCH;
          pos_d   = '0;
          hit_d   = 1'b0;
          fin_d   = 1'b0;
        end else if (next_go) begin
          state_d = ATS_FETCH;
          pos_d   = pos_q + 1'b1;
          hit_d   = 1'b0;
        end
      end
      ATS_FETCH: state_d = ATS_CHECK;
      ATS_CHECK: begin
        if (slot_valid) begin
          capture = 1'b1;
          hit_d   = 1'b1;
          fin_d   = at_last;
          state_d = ATS_IDLE;
        end else if (at_last) begin
          fin_d   = 1'b1;
          state_d = ATS_IDLE;
        end else begin
          pos_d   = pos_q + 1'b1;
          state_d = ATS_FETCH;
        end
      end
      default: state_d = ATS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ATS_IDLE;
      pos_q   <= '0;
      hit_q   <= 1'b0;
      fin_q   <= 1'b0;
    end else if (step_en) begin
      state_q <= state_d;
      pos_q   <= pos_d;
      hit_q   <= hit_d;
      fin_q   <= fin_d;
    end
  end

  always_comb begin
    busy        = (state_q != ATS_IDLE);
    hit         = hit_q;
    fin         = fin_q;
    tbl_rd_en   = (state_q == ATS_FETCH);
    tbl_rd_addr = pos_q;
  end

  // R3: an empty, non-final slot moves the scan exactly one slot on
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ATS_CHECK && !slot_valid && !at_last) |=> (pos_q == AW'($past(pos_q) + 1'b1)));

  // R6: end only appears after the final slot was examined
  a_r6_end_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_q) |-> (pos_q == LAST_SLOT));

  // R2: flags are clean for the whole time a scan is running
  a_r2_busy_clean: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!hit_q && !fin_q));
endmodule

// File: rtl/ats_results.sv
module ats_results (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic [31:0] attr_in,
  input  logic [47:0] mac_in,
  output logic [31:0] attr_q,
  output logic [47:0] mac_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
      mac_q  <= '0;
    end else if (capture) begin
      attr_q <= attr_in;
      mac_q  <= mac_in;
    end
  end
endmodule

// File: rtl/ats_regmux.sv
module ats_regmux
  import ats_pkg::*;
(
  input  logic [1:0]  rd_addr,
  input  logic        busy,
  input  logic        hit,
  input  logic        fin,
  input  logic [31:0] attr,
  input  logic [47:0] mac,
  output logic [31:0] rd_data
);
  always_comb begin
    rd_data = '0;
    case (ats_reg_e'(rd_addr))
      ATS_RA_CTRL: begin
        rd_data[ATS_BUSY_BIT] = busy;
        rd_data[ATS_END_BIT]  = fin;
        rd_data[ATS_HIT_BIT]  = hit;
      end
      ATS_RA_ATTR:   rd_data = attr;
      ATS_RA_MAC_HI: rd_data = mac[47:16];
      ATS_RA_MAC_LO: rd_data = {16'h0000, mac[15:0]};
      default:       rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ats_top.sv
module ats_top
  import ats_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_wr_addr,
  input  logic [31:0]   reg_wr_data,
  input  logic [1:0]    reg_rd_addr,
  output logic [31:0]   reg_rd_data,
  output logic          tbl_rd_en,
  output logic [AW-1:0] tbl_rd_addr,
  input  logic [31:0]   tbl_rd_attr,
  input  logic [47:0]   tbl_rd_mac
);
  logic        busy, hit, fin, capture;
  logic        start_go, next_go;
  logic        slot_valid;
  logic [31:0] res_attr;
  logic [47:0] res_mac;

  always_comb slot_valid = |tbl_rd_attr[ATS_VALID_MSB:ATS_VALID_LSB];

  ats_cmd_decode u_dec (
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_wr_addr),
    .wr_data  (reg_wr_data),
    .busy     (busy),
    .hit      (hit),
    .fin      (fin),
    .start_go (start_go),
    .next_go  (next_go)
  );

  ats_walker #(.DEPTH(DEPTH)) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_go    (start_go),
    .next_go     (next_go),
    .slot_valid  (slot_valid),
    .busy        (busy),
    .hit         (hit),
    .fin         (fin),
    .capture     (capture),
    .tbl_rd_en   (tbl_rd_en),
    .tbl_rd_addr (tbl_rd_addr)
  );

  ats_results u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .attr_in (tbl_rd_attr),
    .mac_in  (tbl_rd_mac),
    .attr_q  (res_attr),
    .mac_q   (res_mac)
  );

  ats_regmux u_mux (
    .rd_addr (reg_rd_addr),
    .busy    (busy),
    .hit     (hit),
    .fin     (fin),
    .attr    (res_attr),
    .mac     (res_mac),
    .rd_data (reg_rd_data)
  );

  // R4: a new hit always exposes an occupied slot's attribute word
  a_r4_hit_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> ((|res_attr[ATS_VALID_MSB:ATS_VALID_LSB]) && (res_attr == $past(tbl_rd_attr))));

  // R2: a scan never finishes without reporting hit or end
  a_r2_done_reports: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (hit || fin));

  // R7: with no accepted command an idle engine stays idle
  a_r7_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_go && !next_go) |=> !busy);
endmodule

// File: tb/ats_top_test.sv
`timescale 1ns/1ps
module ats_top_test;
  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);
  localparam logic [31:0] START = 32'h0000_8004;
  localparam logic [31:0] NEXT  = 32'h0000_8005;

  logic          clk, rst_n;
  logic          reg_wr_en;
  logic [1:0]    reg_wr_addr, reg_rd_addr;
  logic [31:0]   reg_wr_data, reg_rd_data;
  logic          tbl_rd_en;
  logic [AW-1:0] tbl_rd_addr;
  logic [31:0]   tbl_rd_attr;
  logic [47:0]   tbl_rd_mac;

  logic [31:0] mem_attr [DEPTH];
  logic [47:0] mem_mac  [DEPTH];

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  bit          m_busy, m_hit, m_end;
  int          m_left, m_tgt, m_pos, m_rdaddr;
  logic [31:0] m_attr;
  logic [47:0] m_mac;

  ats_top #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr),
    .tbl_rd_attr(tbl_rd_attr), .tbl_rd_mac(tbl_rd_mac)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (tbl_rd_en) begin
      tbl_rd_attr <= mem_attr[tbl_rd_addr];
      tbl_rd_mac  <= mem_mac[tbl_rd_addr];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int find_from(input int from);
    for (int k = from; k < DEPTH; k++)
      if (mem_attr[k][31:24] != 8'h00) return k;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: exp_rd = {16'h0, m_busy, m_end, m_hit, 13'h0};
      2'd1: exp_rd = m_attr;
      2'd2: exp_rd = m_mac[47:16];
      default: exp_rd = {16'h0, m_mac[15:0]};
    endcase
  endfunction

  task automatic launch(input int from);
    m_tgt    = find_from(from);
    m_busy   = 1;
    m_hit    = 0;
    m_end    = 0;
    m_rdaddr = from;
    m_left   = (m_tgt >= 0) ? 2 * (m_tgt - from + 1) : 2 * (DEPTH - from);
  endtask

  // behavioural reference model, advanced on every clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_hit = 0; m_end = 0; m_left = 0; m_tgt = -1; m_pos = 0;
      m_rdaddr = 0; m_attr = '0; m_mac = '0;
    end else if (m_busy) begin
      m_left--;
      if (m_left == 0) begin
        m_busy = 0;
        if (m_tgt >= 0) begin
          m_hit  = 1;
          m_end  = (m_tgt == DEPTH - 1);
          m_attr = mem_attr[m_tgt];
          m_mac  = mem_mac[m_tgt];
          m_pos  = m_tgt;
        end else begin
          m_end = 1;
        end
      end
    end else if (reg_wr_en && reg_wr_addr == 2'd0) begin
      if (reg_wr_data == START) launch(0);
      else if (reg_wr_data == NEXT && m_hit && !m_end) launch(m_pos + 1);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk((reg_rd_addr == 2'd0) ? "R2 status" : "R4 result", reg_rd_data, exp_rd(reg_rd_addr));
      if (tbl_rd_en) begin
        chk("R8 read only while busy", {31'h0, m_busy}, 32'h1);
        chk("R8 slot order", 32'(tbl_rd_addr), 32'(m_rdaddr));
        m_rdaddr++;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    @(posedge clk); #1;
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_rd_addr = a;
    @(negedge clk);
    d = reg_rd_data;
    @(posedge clk); #1;
    reg_rd_addr = 2'd0;
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (reg_rd_data[15]) cnt++;
      else break;
    end
    @(posedge clk); #1;
  endtask

  task automatic run_cmd(input logic [31:0] cmd, input int exp_cycles, input string tag);
    int c;
    wr(2'd0, cmd);
    wait_idle(c);
    chk(tag, 32'(c), 32'(exp_cycles));
  endtask

  task automatic check_result(input string tag, input int slot);
    logic [31:0] v;
    rd(2'd1, v); chk(tag, v, mem_attr[slot]);
    chk({tag, " port map"}, {24'h0, v[11:4]}, {24'h0, mem_attr[slot][11:4]});
    rd(2'd2, v); chk(tag, v, mem_mac[slot][47:16]);
    rd(2'd3, v); chk(tag, v, {16'h0, mem_mac[slot][15:0]});
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int c;
    rst_n = 0; reg_wr_en = 0; reg_wr_addr = 0; reg_wr_data = 0; reg_rd_addr = 0;
    tbl_rd_attr = '0; tbl_rd_mac = '0;
    for (int i = 0; i < DEPTH; i++) begin mem_attr[i] = '0; mem_mac[i] = '0; end
    mem_attr[3]  = 32'h0100_0AB0; mem_mac[3]  = 48'h0011_2233_4455;
    mem_attr[7]  = 32'h8000_0FF0; mem_mac[7]  = 48'hA0B0_C0D0_E0F0;
    mem_attr[31] = 32'h7F00_0010; mem_mac[31] = 48'h0203_0405_0607;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk("R1 read enable", {31'h0, tbl_rd_en}, 32'h0);
    rd(2'd0, v); chk("R1 control", v, 32'h0);
    rd(2'd1, v); chk("R1 attribute", v, 32'h0);
    rd(2'd2, v); chk("R1 mac high", v, 32'h0);
    rd(2'd3, v); chk("R1 mac low", v, 32'h0);

    // R3: slots 0..2 empty, hit at slot 3 after 4 slots
    run_cmd(START, 8, "R3 skip cycles");
    rd(2'd0, v); chk("R4 hit flag", v, 32'h0000_2000);
    check_result("R4 slot 3", 3);

    // R7: a second start while busy is ignored
    wr(2'd0, START);
    wr(2'd0, START);
    wait_idle(c);
    chk("R7 start while busy", 32'(c), 32'd7);
    check_result("R7 slot 3 again", 3);

    // R5: resume finds slot 7
    run_cmd(NEXT, 8, "R5 resume cycles");
    check_result("R5 slot 7", 7);

    // R6: hit on the last slot sets hit and end together
    run_cmd(NEXT, 48, "R6 last slot cycles");
    rd(2'd0, v); chk("R6 hit and end", v, 32'h0000_6000);
    check_result("R6 slot 31", 31);

    // R7: resume after end, stray control value, result-register writes
    wr(2'd0, NEXT);
    repeat (4) @(posedge clk); #1;
    rd(2'd0, v); chk("R7 resume after end", v, 32'h0000_6000);
    wr(2'd0, 32'h0000_1234);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'hFFFF_FFFF);
    repeat (2) @(posedge clk); #1;
    rd(2'd0, v); chk("R7 stray writes control", v, 32'h0000_6000);
    rd(2'd1, v); chk("R7 stray writes attribute", v, mem_attr[31]);

    // R3: occupied slot 0 ends the scan after one slot
    mem_attr[0] = 32'h0100_0FF0; mem_mac[0] = 48'hDEAD_BEEF_0102;
    run_cmd(START, 2, "R3 slot 0 cycles");
    rd(2'd0, v); chk("R3 slot 0 flags", v, 32'h0000_2000);
    check_result("R4 slot 0", 0);

    // R6: empty table runs to the end with hit clear, results kept
    for (int i = 0; i < DEPTH; i++) mem_attr[i] = '0;
    run_cmd(START, 2 * DEPTH, "R6 empty scan cycles");
    rd(2'd0, v); chk("R6 end without hit", v, 32'h0000_4000);
    rd(2'd1, v); chk("R6 results kept", v, 32'h0100_0FF0);

    // R7: resume with hit clear is ignored
    wr(2'd0, NEXT);
    repeat (3) @(posedge clk); #1;
    rd(2'd0, v); chk("R7 resume without hit", v, 32'h0000_4000);

    finish_run();
  end
endmodule